// File: doc/BRIEF.md
# Bank-Switched Output Port

This block sits on the memory bus of a small processor with a 5-bit address space. It claims two addresses there. One holds an 8-bit bank selector that every bank shares and that is always reachable. The other is a window onto one of several physical 8-bit output latches. A write to the window changes only the latch the selector currently names. A read of the window returns that latch. Each latch drives eight device lines, and all latches appear together on one flat output vector.

Software switches banks by writing the selector. Because the selector itself is never banked, a program can always get back to any earlier bank. Because every latch can be read back, software can test a bit, toggle it with XOR, or set or clear it by read-modify-write. Selector values at or above the number of implemented banks give a dead window: reads return zero and writes are dropped. The bus is a plain strobe interface with no back-pressure. Writes take effect on the clock edge that carries the strobe. Read data is combinational from the current address.

Top module: `bank_out_port`

## Requirements
- R1: After reset the selector reads 0 and every bit of `dev_lines` is 0.
- R2: A write to the selector address (default 31) stores the full 8-bit value. A read of that address returns it, with `bus_rd_hit` high, whichever bank is selected.
- R3: A write to the window address (default 30) while the selector holds a valid bank k loads only latch k, on the same edge as the strobe. Every other latch holds its value.
- R4: A read of the window address with a valid selector k returns latch k, with `bus_rd_hit` high.
- R5: Changing the selector leaves every latch and every bit of `dev_lines` unchanged.
- R6: While the selector is at or above NUM_BANKS, a read of the window returns 0 and a write to the window changes no latch.
- R7: Latch k bit b drives `dev_lines[k*8+b]`.
- R8: Any other address reads 0 with `bus_rd_hit` low, and a write to it changes neither the selector nor any latch.
- R9: A read, XOR with a mask, and write-back through the window inverts exactly the masked bits of the selected latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Bus address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for `bus_addr`, combinational |
| bus_rd_hit | output | 1 | High when `bus_addr` is one of the two claimed addresses |
| dev_lines | output | NUM_BANKS*8 | All latch outputs, bank k bit b at k*8+b |

## Verification
A write is registered on the rising edge that samples the strobe. Its effect therefore shows on `dev_lines`, and on reads of either address, from that edge onward. Reads carry no latency and depend only on the current address and the stored state. The bench drives the bus on falling edges and completes each write at the next rising edge. It checks read data one time step after it sets the address on a falling edge. It compares the whole `dev_lines` vector only at a falling edge after the last write, so every expected value falls exactly one edge after its cause.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] DEF_SEL_ADDR = 5'd31;
  localparam logic [ADDR_W-1:0] DEF_WIN_ADDR = 5'd30;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bop_addr_decode.sv
module bop_addr_decode
  import bop_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEL_ADDR = DEF_SEL_ADDR,
  parameter logic [ADDR_W-1:0] WIN_ADDR = DEF_WIN_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_hit,
  output logic              win_hit
);
  assign sel_hit = (addr == SEL_ADDR);
  assign win_hit = (addr == WIN_ADDR);

  // R8: the two claimed addresses never decode together
  a_r8_exclusive_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_hit && win_hit));
endmodule

// File: rtl/bop_bank_decode.sv
module bop_bank_decode
  import bop_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  byte_t                sel,
  output logic [NUM_BANKS-1:0] bank_match,
  output logic                 sel_valid
);
  localparam int CMP_W = BYTE_W + 1;

  assign sel_valid = ({1'b0, sel} < CMP_W'(NUM_BANKS));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_match
    assign bank_match[i] = (sel == BYTE_W'(i));
  end

  // R6: an out-of-range selector names no bank
  a_r6_invalid_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (bank_match == '0));
  // R3: at most one bank is named
  a_r3_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_match));
endmodule

// File: rtl/bop_latch_array.sv
module bop_latch_array
  import bop_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS-1:0]        bank_we,
  input  logic [NUM_BANKS-1:0]        bank_match,
  input  byte_t                       wr_data,
  output byte_t                       rd_byte,
  output logic [NUM_BANKS*BYTE_W-1:0] lines
);
  byte_t lat_q [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q[i] <= '0;
      else if (bank_we[i]) lat_q[i] <= wr_data;
    end
    assign lines[i*BYTE_W +: BYTE_W] = lat_q[i];

    // R3: a latch moves only under its own enable
    a_r3_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we[i] |=> $stable(lat_q[i]));
    // R3: an enabled latch takes the bus data at that edge
    a_r3_load_selected: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we[i] |=> (lat_q[i] == $past(wr_data)));
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_match[i]) rd_byte = rd_byte | lat_q[i];
  end

  // R1: lines are clear on the first edge out of reset
  a_r1_lines_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lines == '0));
endmodule

// File: rtl/bank_out_port.sv
module bank_out_port
  import bop_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter logic [ADDR_W-1:0] SEL_ADDR = DEF_SEL_ADDR,
  parameter logic [ADDR_W-1:0] WIN_ADDR = DEF_WIN_ADDR
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr_en,
  input  logic [BYTE_W-1:0]           bus_wr_data,
  output logic [BYTE_W-1:0]           bus_rd_data,
  output logic                        bus_rd_hit,
  output logic [NUM_BANKS*BYTE_W-1:0] dev_lines
);
  logic                 sel_hit, win_hit, sel_valid;
  logic [NUM_BANKS-1:0] bank_match, bank_we;
  byte_t                sel_q, win_byte;

  bop_addr_decode #(.SEL_ADDR(SEL_ADDR), .WIN_ADDR(WIN_ADDR)) u_adec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .sel_hit(sel_hit), .win_hit(win_hit)
  );

  // Shared selector: never banked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sel_q <= '0;
    else if (bus_wr_en && sel_hit) sel_q <= bus_wr_data;
  end

  bop_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_bdec (
    .clk(clk), .rst_n(rst_n), .sel(sel_q),
    .bank_match(bank_match), .sel_valid(sel_valid)
  );

  assign bank_we = (bus_wr_en && win_hit && sel_valid) ? bank_match : '0;

  bop_latch_array #(.NUM_BANKS(NUM_BANKS)) u_lat (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_match(bank_match),
    .wr_data(bus_wr_data), .rd_byte(win_byte), .lines(dev_lines)
  );

  always_comb begin
    bus_rd_hit  = sel_hit | win_hit;
    bus_rd_data = '0;
    if (sel_hit)                    bus_rd_data = sel_q;
    else if (win_hit && sel_valid)  bus_rd_data = win_byte;
  end

  // R2: a selector write is visible on the next cycle
  a_r2_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel_hit) |=> (sel_q == $past(bus_wr_data)));
  // R5: a selector write leaves every line alone
  a_r5_switch_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel_hit) |=> $stable(dev_lines));
  // R6: a window write with an invalid selector is dropped
  a_r6_dead_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && win_hit && !sel_valid) |=> $stable(dev_lines));
  // R8: unclaimed addresses touch nothing
  a_r8_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !bus_rd_hit) |=> ($stable(dev_lines) && $stable(sel_q)));
  a_r8_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_hit |-> (bus_rd_data == '0));
  // R1: selector clear on leaving reset
  a_r1_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sel_q == '0));
endmodule

// File: tb/bank_out_port_tb_top.sv
`timescale 1ns/1ps
module bank_out_port_tb_top;
  localparam int NB = 4;
  localparam int NV = 20;
  localparam int VW = 1 + 5 + 8 + 8 + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic            bus_wr_en = 1'b0;
  logic [7:0]      bus_wr_data = '0;
  logic [7:0]      bus_rd_data;
  logic            bus_rd_hit;
  logic [NB*8-1:0] dev_lines;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_out_port #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
    .bus_rd_hit(bus_rd_hit), .dev_lines(dev_lines)
  );

  // {is_write, addr, data, expected read, expected hit}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 5'd31, 8'h02, 8'h00, 1'b0},  // R2 select bank 2
    {1'b0, 5'd31, 8'h00, 8'h02, 1'b1},  // R2 read selector
    {1'b1, 5'd30, 8'hA5, 8'h00, 1'b0},  // R3 load bank 2
    {1'b0, 5'd30, 8'h00, 8'hA5, 1'b1},  // R4 read bank 2
    {1'b1, 5'd31, 8'h00, 8'h00, 1'b0},  // R5 switch to bank 0
    {1'b0, 5'd30, 8'h00, 8'h00, 1'b1},  // R3 bank 0 untouched
    {1'b1, 5'd30, 8'h3C, 8'h00, 1'b0},
    {1'b0, 5'd30, 8'h00, 8'h3C, 1'b1},  // R4
    {1'b1, 5'd31, 8'h02, 8'h00, 1'b0},
    {1'b0, 5'd30, 8'h00, 8'hA5, 1'b1},  // R5 bank 2 kept
    {1'b1, 5'd31, 8'h07, 8'h00, 1'b0},  // R6 out of range
    {1'b0, 5'd30, 8'h00, 8'h00, 1'b1},  // R6 dead read
    {1'b1, 5'd30, 8'hFF, 8'h00, 1'b0},  // R6 dropped write
    {1'b0, 5'd31, 8'h00, 8'h07, 1'b1},  // R2 selector kept full value
    {1'b1, 5'd31, 8'h02, 8'h00, 1'b0},
    {1'b0, 5'd30, 8'h00, 8'hA5, 1'b1},  // R6 bank 2 not hit
    {1'b0, 5'd05, 8'h00, 8'h00, 1'b0},  // R8 foreign read
    {1'b1, 5'd05, 8'h77, 8'h00, 1'b0},  // R8 foreign write
    {1'b0, 5'd30, 8'h00, 8'hA5, 1'b1},  // R8 no effect on latch
    {1'b0, 5'd31, 8'h00, 8'h02, 1'b1}   // R8 no effect on selector
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rd_data; h = bus_rd_hit;
  endtask

  initial begin
    logic [7:0] rd;
    logic       hit;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lines in reset", 32'(dev_lines), 32'h0);
    rst_n = 1'b1;
    bus_read(5'd31, rd, hit);
    check("R1 selector after reset", 32'(rd), 32'h0);
    check("R1 lines after reset", 32'(dev_lines), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][VW-1]) bus_write(VEC[i][21:17], VEC[i][16:9]);
      else begin
        bus_read(VEC[i][21:17], rd, hit);
        check($sformatf("R2-R8 vec%0d data", i), 32'(rd), 32'(VEC[i][8:1]));
        check($sformatf("R2-R8 vec%0d hit", i), 32'(hit), 32'(VEC[i][0]));
      end
    end

    // R7 flat vector layout: bank2=A5, bank0=3C
    @(negedge clk);
    check("R7 dev_lines map", 32'(dev_lines), 32'h00A5003C);

    // R9 toggle bit 4 of bank 2 by read, XOR, write back
    bus_read(5'd30, rd, hit);
    bus_write(5'd30, rd ^ 8'h10);
    check("R9 toggled line", 32'(dev_lines[2*8+4]), 32'h1);
    check("R9 others kept", 32'(dev_lines), 32'h00B5003C);
    bus_read(5'd30, rd, hit);
    bus_write(5'd30, rd ^ 8'h81);
    check("R9 second toggle", 32'(dev_lines), 32'h0034003C);

    // R3 top bank edge
    bus_write(5'd31, 8'd3);
    bus_write(5'd30, 8'h5A);
    check("R3 last bank", 32'(dev_lines), 32'h5A34003C);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'(dev_lines), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(5'd31, rd, hit);
    check("R1 selector cleared", 32'(rd), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule